// File: doc/BRIEF.md
# Counter-Overflow Interrupt Controller

This block holds the pending, enable and delegation state for one local interrupt that reports performance-counter overflow. Every counter drives a one-cycle overflow request line. Any request sets a single sticky pending bit, which software clears once it has collected the overflowed counters. Software reaches the state through a small register port. The port offers a machine-level view and a supervisor-level view of the pending and enable registers, plus the delegation register. In every view the interrupt occupies bit 13 of the data word.

The delegation bit selects the privilege level that takes the interrupt. When it is clear, the machine interrupt line can assert and the supervisor view is hidden: it reads as zero and ignores writes. When it is set, the supervisor line can assert and the supervisor view mirrors the machine bits. Trap entry, prioritising against other interrupt sources and the remaining interrupt register bits belong to the surrounding core.

Top module: `cntovf_irq`

## Requirements
- R1: After reset, pending, enable and delegation are zero, every register select reads all-zero data, and both interrupt lines are low.
- R2: A high level on any overflow request bit during a clock edge makes pending read as 1 after that edge.
- R3: Requests on several counters in the same cycle form one pending event, and a single software write of 0 clears it.
- R4: The machine pending view (select 0) writes pending from data bit 13 and reads pending on bit 13, with every other read bit zero.
- R5: When an overflow request and a software clear of pending fall on the same edge, pending stays 1.
- R6: The machine enable view (select 1) writes and reads enable on bit 13.
- R7: The delegation view (select 4) writes and reads the delegation bit on bit 13.
- R8: The machine interrupt line equals pending AND enable AND NOT delegation.
- R9: The supervisor interrupt line equals pending AND enable AND delegation.
- R10: While delegation is 0, the supervisor pending view (select 2) and the supervisor enable view (select 3) read as zero, and writes to them change nothing.
- R11: While delegation is 1, selects 2 and 3 read and write the same pending and enable bits as selects 0 and 1.
- R12: Selects 5 to 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ovfReq | input | NUM_CNT (29) | Per-counter overflow request pulses |
| csrWrEn | input | 1 | Write strobe for the selected view |
| csrSel | input | 3 | View select: 0 machine pending, 1 machine enable, 2 supervisor pending, 3 supervisor enable, 4 delegation |
| csrWrData | input | XLEN (64) | Write data; only bit 13 is used |
| csrRdData | output | XLEN (64) | Read data of the selected view, combinational |
| mIrq | output | 1 | Machine-level interrupt line |
| sIrq | output | 1 | Supervisor-level interrupt line |

## Verification
Read data is combinational from the select and the stored state, so it is due in the same cycle as the select. Pending, enable and delegation change on the clock edge that samples a request or a write. The interrupt lines follow that state with no further register, so they are due just after the same edge. The bench applies its inputs on the falling edge and checks read data 1 ns later, against a model that still holds the pre-edge state. After the rising edge it updates the model and checks both interrupt lines 1 ns later.

// File: rtl/cntovf_pkg.sv
package cntovf_pkg;
  localparam int IRQ_BIT = 13;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_MPEND = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MENAB = 3'd1;
  localparam logic [SEL_W-1:0] SEL_SPEND = 3'd2;
  localparam logic [SEL_W-1:0] SEL_SENAB = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DELEG = 3'd4;

  // Write strobes from control to datapath
  typedef struct packed {
    logic pendWr;
    logic enWr;
    logic delegWr;
    logic wrVal;
  } ctlStrobe_t;

  // Stored state returned by the datapath
  typedef struct packed {
    logic pend;
    logic en;
    logic deleg;
  } irqState_t;
endpackage

// File: rtl/cntovf_ctl.sv
module cntovf_ctl
  import cntovf_pkg::*;
(
  input  logic             csrWrEn,
  input  logic [SEL_W-1:0] csrSel,
  input  logic             wrBit,
  input  irqState_t        state,
  output ctlStrobe_t       strobe,
  output logic             rdBit
);
  always_comb begin
    strobe = '0;
    strobe.wrVal = wrBit;
    rdBit = 1'b0;
    case (csrSel)
      SEL_MPEND: begin
        rdBit = state.pend;
        strobe.pendWr = csrWrEn;
      end
      SEL_MENAB: begin
        rdBit = state.en;
        strobe.enWr = csrWrEn;
      end
      SEL_SPEND: begin
        rdBit = state.deleg & state.pend;
        strobe.pendWr = csrWrEn & state.deleg;
      end
      SEL_SENAB: begin
        rdBit = state.deleg & state.en;
        strobe.enWr = csrWrEn & state.deleg;
      end
      SEL_DELEG: begin
        rdBit = state.deleg;
        strobe.delegWr = csrWrEn;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cntovf_dp.sv
module cntovf_dp
  import cntovf_pkg::*;
#(
  parameter int NUM_CNT = 29
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CNT-1:0] ovfReq,
  input  ctlStrobe_t         strobe,
  output irqState_t          state,
  output logic               mIrq,
  output logic               sIrq
);
  logic anyReq;
  logic pendQ, enQ, delegQ;

  assign anyReq = |ovfReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= 1'b0;
      enQ    <= 1'b0;
      delegQ <= 1'b0;
    end else begin
      if (anyReq)             pendQ <= 1'b1;
      else if (strobe.pendWr) pendQ <= strobe.wrVal;
      if (strobe.enWr)        enQ <= strobe.wrVal;
      if (strobe.delegWr)     delegQ <= strobe.wrVal;
    end
  end

  assign state = '{pend: pendQ, en: enQ, deleg: delegQ};
  assign mIrq  = pendQ & enQ & ~delegQ;
  assign sIrq  = pendQ & enQ & delegQ;

  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> pendQ);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !(strobe.pendWr && !strobe.wrVal)) |=> pendQ);

  p_one_line_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mIrq, sIrq}));

  p_ena_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enWr |=> $stable(enQ));
endmodule

// File: rtl/cntovf_irq.sv
module cntovf_irq
  import cntovf_pkg::*;
#(
  parameter int NUM_CNT = 29,
  parameter int XLEN    = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CNT-1:0] ovfReq,
  input  logic               csrWrEn,
  input  logic [SEL_W-1:0]   csrSel,
  input  logic [XLEN-1:0]    csrWrData,
  output logic [XLEN-1:0]    csrRdData,
  output logic               mIrq,
  output logic               sIrq
);
  ctlStrobe_t strobe;
  irqState_t  state;
  logic       rdBit;
  logic       unusedWrBits;

  assign unusedWrBits = ^{csrWrData[XLEN-1:IRQ_BIT+1], csrWrData[IRQ_BIT-1:0]};

  cntovf_ctl u_ctl (
    .csrWrEn (csrWrEn),
    .csrSel  (csrSel),
    .wrBit   (csrWrData[IRQ_BIT]),
    .state   (state),
    .strobe  (strobe),
    .rdBit   (rdBit)
  );

  cntovf_dp #(.NUM_CNT(NUM_CNT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ovfReq (ovfReq),
    .strobe (strobe),
    .state  (state),
    .mIrq   (mIrq),
    .sIrq   (sIrq)
  );

  assign csrRdData = XLEN'(rdBit) << IRQ_BIT;

  p_sview_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && (csrSel == SEL_SPEND) && !state.deleg && !(|ovfReq))
      |=> $stable(state.pend));

  p_deleg_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && (csrSel == SEL_DELEG)) |=> (state.deleg == $past(csrWrData[IRQ_BIT])));

  p_sview_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && (csrSel == SEL_SENAB) && state.deleg) |=> (state.en == $past(csrWrData[IRQ_BIT])));
endmodule

// File: tb/cntovf_irq_tb.sv
`timescale 1ns/1ps
module cntovf_irq_tb;
  localparam int NC = 29;
  localparam int XL = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0] ovfReq = '0;
  logic csrWrEn = 1'b0;
  logic [2:0] csrSel = '0;
  logic [XL-1:0] csrWrData = '0;
  logic [XL-1:0] csrRdData;
  logic mIrq, sIrq;

  int checks = 0;
  int errors = 0;
  bit mPend = 0, mEn = 0, mDlg = 0;

  always #2.5 clk = ~clk;

  cntovf_irq #(.NUM_CNT(NC), .XLEN(XL)) u_dut (
    .clk(clk), .rstN(rstN), .ovfReq(ovfReq), .csrWrEn(csrWrEn),
    .csrSel(csrSel), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .mIrq(mIrq), .sIrq(sIrq)
  );

  function automatic logic [XL-1:0] expRd(input logic [2:0] s);
    logic b;
    case (s)
      3'd0: b = mPend;
      3'd1: b = mEn;
      3'd2: b = mDlg & mPend;
      3'd3: b = mDlg & mEn;
      3'd4: b = mDlg;
      default: b = 1'b0;
    endcase
    return XL'(b) << 13;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] s, input logic [XL-1:0] d,
                      input logic [NC-1:0] r, input string tag);
    bit nP, nE, nD, b;
    @(negedge clk);
    csrWrEn = we; csrSel = s; csrWrData = d; ovfReq = r;
    #1;
    chk(csrRdData == expRd(s), tag, "read", csrRdData, expRd(s));
    nP = mPend; nE = mEn; nD = mDlg; b = d[13];
    if (we) begin
      case (s)
        3'd0: nP = b;
        3'd1: nE = b;
        3'd2: if (mDlg) nP = b;
        3'd3: if (mDlg) nE = b;
        3'd4: nD = b;
        default: ;
      endcase
    end
    if (|r) nP = 1'b1;
    @(posedge clk);
    mPend = nP; mEn = nE; mDlg = nD;
    #1;
    chk(mIrq == (mPend & mEn & ~mDlg), tag, "mIrq", XL'(mIrq), XL'(mPend & mEn & ~mDlg));
    chk(sIrq == (mPend & mEn & mDlg), tag, "sIrq", XL'(sIrq), XL'(mPend & mEn & mDlg));
  endtask

  task automatic peek(input logic [2:0] s, input string tag);
    @(negedge clk);
    csrWrEn = 1'b0; csrSel = s; ovfReq = '0;
    #1;
    chk(csrRdData == expRd(s), tag, "read", csrRdData, expRd(s));
  endtask

  localparam logic [XL-1:0] B13 = 64'h2000;

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    for (int s = 0; s < 8; s++) begin
      csrSel = 3'(s);
      #1;
      chk(csrRdData == '0, "R1", "reset read", csrRdData, '0);
    end
    chk(!mIrq && !sIrq, "R1", "reset lines", XL'({mIrq, sIrq}), '0);
    @(negedge clk);
    rstN = 1'b1;

    step(1, 3'd1, B13, '0, "R6");           // enable on
    peek(3'd1, "R6");
    step(0, 3'd0, '0, NC'(1), "R2");        // one counter
    peek(3'd0, "R2");
    step(1, 3'd0, '0, '0, "R8");            // clear
    step(0, 3'd0, '0, '1, "R3");            // all counters at once
    step(1, 3'd0, '0, '0, "R3");            // single clear
    peek(3'd0, "R3");
    step(1, 3'd0, '1, '0, "R4");            // all ones, only bit 13 kept
    peek(3'd0, "R4");
    step(1, 3'd0, '0, NC'(1) << 28, "R5");  // clear + request same edge
    peek(3'd0, "R5");
    step(1, 3'd0, '0, '0, "R4");
    step(1, 3'd2, B13, '0, "R10");          // ignored, not delegated
    peek(3'd0, "R10");
    step(1, 3'd3, '0, '0, "R10");
    peek(3'd1, "R10");
    step(0, 3'd2, '0, NC'(4), "R10");
    peek(3'd2, "R10");
    step(1, 3'd4, B13, '0, "R7");           // delegate
    peek(3'd4, "R7");
    peek(3'd2, "R11");
    step(0, 3'd0, '0, '0, "R9");
    step(1, 3'd2, '0, '0, "R11");           // clear through supervisor view
    peek(3'd0, "R11");
    step(1, 3'd3, '0, '0, "R11");
    peek(3'd1, "R11");
    step(1, 3'd3, B13, NC'(8), "R9");
    step(1, 3'd5, '1, '0, "R12");
    step(1, 3'd7, '0, '0, "R12");
    for (int s = 0; s < 5; s++) peek(3'(s), "R12");
    step(1, 3'd4, '0, '0, "R8");

    void'($urandom(32'd4711));
    for (int i = 0; i < 3000; i++) begin
      logic [NC-1:0] r;
      r = (($urandom % 6) == 0) ? NC'($urandom) : '0;
      step(1'($urandom), 3'($urandom), {$urandom, $urandom}, r, "R8/R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule